// File: doc/BRIEF.md
# Parity-Protected Interrupt Vector Table

This block holds the handler addresses that an interrupt controller hands to a processor. There is one 32-bit word per slot, and each word is stored with an even-parity bit. Slot 0 holds the default handler. Channel `c` keeps its handler in slot `c+1`. The priority logic upstream presents a channel index, or a "no channel" indication, with a fetch strike. One clock later the block drives the selected handler address on `vec_addr`.

When parity checking is armed and a fetched word fails its parity check, the block does three things:
- It drives the programmable fallback address on `vec_addr` instead of the corrupt word.
- It captures the byte address of the bad slot.
- It raises a sticky error flag.

Checking is armed only when the 4-bit key register holds `0xA`. Software reaches the slots and the control registers over a simple 32-bit register bus. Reads on that bus have no side effects and return data one clock after the address.

The error capture is a two-state machine:
- `ERR_IDLE`: no error is recorded.
- `ERR_HELD`: an error is recorded.

Its transitions are:
- `IDLE->HELD` on a parity hit.
- `HELD->IDLE` on a clear with no hit in the same cycle.
- `HELD->HELD` (recapture) on a clear together with a hit.
- `HELD->HELD` (hold) in every other case. While holding, later hits leave the captured address unchanged.

A test-only port flips the stored parity bit of one slot so that errors can be injected.

Bus map, byte addresses:
- Slot `s` is at `4*s`, for `s < ENTRIES`. Only aligned writes store.
- `0x200` holds the key in bits 3:0.
- `0x204` holds the fallback address.
- `0x208` holds the captured error byte address in bits 8:0. This register is read-only.
- `0x20C` holds the error flag in bit 0. Writing 1 to it clears the flag.

Top module: `vt_vector_table`

## Requirements
- R1: After reset, the key, fallback, error-address and flag registers all read 0, and `vec_addr` is 0.
- R2: A bus write to slot `s` (byte address `4*s`) or to the fallback register stores the data. A bus read of that address returns it on `bus_rdata` one clock after the address is presented.
- R3: A fetch of channel `c < NUM_CHAN` with `vec_none`=0 drives the word of slot `c+1` on `vec_addr` on the edge that samples `vec_req`. Without `vec_req`, `vec_addr` holds its value.
- R4: A fetch with `vec_none`=1, or with `vec_chan >= NUM_CHAN`, returns slot 0.
- R5: With key `0xA`, a fetch of a slot whose stored parity is wrong returns the fallback register value.
- R6: With any key other than `0xA`, a slot with wrong parity returns its stored word, and the flag stays 0.
- R7: A parity hit sets the flag (bit 0 of `0x20C`). It also captures the slot's byte address `4*s` in bits 8:0 of `0x208`, so that `addr>>2` gives the slot number.
- R8: While the flag is set, further hits leave the captured address unchanged.
- R9: Writing 1 to bit 0 of `0x20C` clears the flag. Writing 0 there has no effect.
- R10: A clear and a new hit in the same cycle leave the flag set, with the new hit's address captured.
- R11: Rewriting a corrupted slot over the bus stores fresh parity. Later fetches then return the new word with no error.
- R12: A pulse on `inj_en` inverts the stored parity bit of slot `inj_slot` only. A second pulse restores it.
- R13: Bus reads of a slot return the stored word without a parity check and never set the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 10 | Register bus byte address |
| bus_wr | input | 1 | Register bus write strobe |
| bus_wdata | input | 32 | Register bus write data |
| bus_rdata | output | 32 | Register bus read data, one clock after the address |
| vec_req | input | 1 | Fetch strike |
| vec_none | input | 1 | Fetch the default handler (slot 0) |
| vec_chan | input | SLOT_W (4) | Channel index |
| vec_addr | output | 32 | Registered handler address |
| inj_en | input | 1 | Test-only: invert the parity bit of one slot |
| inj_slot | input | SLOT_W (4) | Test-only: slot whose parity is inverted |

## Verification
Two actions can fall in the same clock edge: a software clear of the sticky flag and a fetch that hits a corrupt slot. The bench first records one error. It then corrupts a second slot and, on a single negative edge, drives both a write of 1 to the flag register and a fetch of that second slot. The result is judged through the bus: the flag must still read 1, and the captured address must be the second slot's. The same sequence without the clear must keep the first address, and the clear alone must drop the flag.

// File: rtl/vt_pkg.sv
package vt_pkg;

    // Error capture states
    typedef enum logic {
        ERR_IDLE = 1'b0,
        ERR_HELD = 1'b1
    } err_state_t;

    localparam int          BUS_AW   = 10;
    localparam int          EADDR_W  = 9;
    localparam logic [3:0]  CHK_KEY  = 4'hA;

    localparam logic [BUS_AW-1:0] REG_KEY  = 10'h200;
    localparam logic [BUS_AW-1:0] REG_FB   = 10'h204;
    localparam logic [BUS_AW-1:0] REG_EADR = 10'h208;
    localparam logic [BUS_AW-1:0] REG_FLAG = 10'h20C;

endpackage

// File: rtl/vt_entry_store.sv
module vt_entry_store #(
    parameter int ENTRIES = 16,
    parameter int SLOT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SLOT_W-1:0] wr_slot,
    input  logic [31:0]       wr_data,
    input  logic              inj_en,
    input  logic [SLOT_W-1:0] inj_slot,
    input  logic [SLOT_W-1:0] a_slot,
    output logic [31:0]       a_data,
    output logic              a_par,
    input  logic [SLOT_W-1:0] b_slot,
    output logic [31:0]       b_data
);

    logic [31:0] data_q [ENTRIES];
    logic        par_q  [ENTRIES];

    for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                data_q[i] <= '0;
                par_q[i]  <= 1'b0;
            end else if (wr_en && (wr_slot == SLOT_W'(i))) begin
                data_q[i] <= wr_data;
                par_q[i]  <= ^wr_data;
            end else if (inj_en && (inj_slot == SLOT_W'(i))) begin
                par_q[i]  <= ~par_q[i];
            end
        end
    end

    assign a_data = data_q[a_slot];
    assign a_par  = par_q[a_slot];
    assign b_data = data_q[b_slot];

    AST_WRITE_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && (a_slot == wr_slot) |=> (^{data_q[$past(wr_slot)], par_q[$past(wr_slot)]}) == 1'b0)
        else $error("write left bad parity"); // R11

endmodule

// File: rtl/vt_vec_fetch.sv
module vt_vec_fetch #(
    parameter int NUM_CHAN = 15,
    parameter int SLOT_W   = 4,
    parameter int EADDR_W  = 9
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req,
    input  logic               none,
    input  logic [SLOT_W-1:0]  chan,
    input  logic               chk_en,
    input  logic [31:0]        fallback,
    output logic [SLOT_W-1:0]  slot,
    input  logic [31:0]        slot_data,
    input  logic               slot_par,
    output logic               hit,
    output logic [EADDR_W-1:0] hit_addr,
    output logic [31:0]        vec_addr
);

    localparam logic [SLOT_W:0] CHAN_LIM = (SLOT_W+1)'(NUM_CHAN);

    logic out_of_range;
    logic bad_par;

    assign out_of_range = ({1'b0, chan} >= CHAN_LIM);
    assign slot     = (none || out_of_range) ? '0 : (chan + SLOT_W'(1));
    assign bad_par  = ^{slot_data, slot_par};
    assign hit      = req && chk_en && bad_par;
    assign hit_addr = EADDR_W'({slot, 2'b00});

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_addr <= '0;
        end else if (req) begin
            vec_addr <= hit ? fallback : slot_data;
        end
    end

    AST_VEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> $stable(vec_addr))
        else $error("vector moved without fetch"); // R3
    AST_VEC_FALLBACK: assert property (@(posedge clk) disable iff (!rst_n)
        req && hit |=> vec_addr == $past(fallback))
        else $error("fallback not returned"); // R5
    AST_VEC_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        req && !hit |=> vec_addr == $past(slot_data))
        else $error("stored word not returned"); // R6

endmodule

// File: rtl/vt_err_fsm.sv
module vt_err_fsm
    import vt_pkg::*;
#(
    parameter int EADDR_W = 9
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               hit,
    input  logic [EADDR_W-1:0] hit_addr,
    input  logic               clr,
    output logic               flag,
    output logic [EADDR_W-1:0] err_addr
);

    err_state_t state_q, state_d;
    logic       capture;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ERR_IDLE;
        else        state_q <= state_d;
    end

    // Next state and capture decision
    always_comb begin
        state_d = state_q;
        capture = 1'b0;
        unique case (state_q)
            ERR_IDLE: begin
                if (hit) begin
                    state_d = ERR_HELD;
                    capture = 1'b1;
                end
            end
            ERR_HELD: begin
                if (clr && hit) begin
                    capture = 1'b1;
                end else if (clr) begin
                    state_d = ERR_IDLE;
                end
            end
            default: state_d = ERR_IDLE;
        endcase
    end

    // Outputs
    always_ff @(posedge clk) begin
        if (!rst_n)       err_addr <= '0;
        else if (capture) err_addr <= hit_addr;
    end

    assign flag = (state_q == ERR_HELD);

    AST_HIT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> flag)
        else $error("hit did not set flag"); // R7
    AST_HELD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        flag && !clr |=> flag && $stable(err_addr))
        else $error("held error changed"); // R8
    AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        flag && clr && !hit |=> !flag)
        else $error("clear ignored"); // R9
    AST_RECAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        flag && clr && hit |=> flag && err_addr == $past(hit_addr))
        else $error("collision lost new error"); // R10

endmodule

// File: rtl/vt_vector_table.sv
module vt_vector_table
    import vt_pkg::*;
#(
    parameter int NUM_CHAN = 15,
    parameter int ENTRIES  = NUM_CHAN + 1,
    parameter int SLOT_W   = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [9:0]        bus_addr,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              vec_req,
    input  logic              vec_none,
    input  logic [SLOT_W-1:0] vec_chan,
    output logic [31:0]       vec_addr,
    input  logic              inj_en,
    input  logic [SLOT_W-1:0] inj_slot
);

    localparam logic [7:0] ENT_LIM = 8'(ENTRIES);

    logic [3:0]         key_q;
    logic [31:0]        fb_q;
    logic               slot_sel;
    logic               ent_wr;
    logic               clr;
    logic [SLOT_W-1:0]  bus_slot;
    logic [SLOT_W-1:0]  f_slot;
    logic [31:0]        f_data;
    logic               f_par;
    logic [31:0]        b_data;
    logic               hit;
    logic [EADDR_W-1:0] hit_addr;
    logic               flag;
    logic [EADDR_W-1:0] err_addr;

    assign slot_sel = !bus_addr[9] && ({1'b0, bus_addr[8:2]} < ENT_LIM);
    assign ent_wr   = bus_wr && slot_sel && (bus_addr[1:0] == 2'b00);
    assign bus_slot = bus_addr[SLOT_W+1:2];
    assign clr      = bus_wr && (bus_addr == REG_FLAG) && bus_wdata[0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            key_q <= '0;
            fb_q  <= '0;
        end else if (bus_wr) begin
            if (bus_addr == REG_KEY) key_q <= bus_wdata[3:0];
            if (bus_addr == REG_FB)  fb_q  <= bus_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (slot_sel) begin
            bus_rdata <= b_data;
        end else begin
            unique case (bus_addr)
                REG_KEY:  bus_rdata <= {28'd0, key_q};
                REG_FB:   bus_rdata <= fb_q;
                REG_EADR: bus_rdata <= {{(32-EADDR_W){1'b0}}, err_addr};
                REG_FLAG: bus_rdata <= {31'd0, flag};
                default:  bus_rdata <= '0;
            endcase
        end
    end

    vt_entry_store #(.ENTRIES(ENTRIES), .SLOT_W(SLOT_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (ent_wr),
        .wr_slot (bus_slot),
        .wr_data (bus_wdata),
        .inj_en  (inj_en),
        .inj_slot(inj_slot),
        .a_slot  (f_slot),
        .a_data  (f_data),
        .a_par   (f_par),
        .b_slot  (bus_slot),
        .b_data  (b_data)
    );

    vt_vec_fetch #(.NUM_CHAN(NUM_CHAN), .SLOT_W(SLOT_W), .EADDR_W(EADDR_W)) u_fetch (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (vec_req),
        .none     (vec_none),
        .chan     (vec_chan),
        .chk_en   (key_q == CHK_KEY),
        .fallback (fb_q),
        .slot     (f_slot),
        .slot_data(f_data),
        .slot_par (f_par),
        .hit      (hit),
        .hit_addr (hit_addr),
        .vec_addr (vec_addr)
    );

    vt_err_fsm #(.EADDR_W(EADDR_W)) u_err (
        .clk     (clk),
        .rst_n   (rst_n),
        .hit     (hit),
        .hit_addr(hit_addr),
        .clr     (clr),
        .flag    (flag),
        .err_addr(err_addr)
    );

    AST_KEY_GATES: assert property (@(posedge clk) disable iff (!rst_n)
        key_q != CHK_KEY |=> $stable(flag) || !flag)
        else $error("flag raised with checking off"); // R6

endmodule

// File: tb/vt_vector_table_bench.sv
module vt_vector_table_bench;

    localparam int NCH = 15;
    localparam int NS  = 16;
    localparam logic [31:0] FB = 32'hFA11_BAC0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [9:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        vec_req = 1'b0;
    logic        vec_none = 1'b0;
    logic [3:0]  vec_chan = '0;
    logic [31:0] vec_addr;
    logic        inj_en = 1'b0;
    logic [3:0]  inj_slot = '0;

    int checks = 0;
    int fails  = 0;
    logic [31:0] expd [NS];
    logic [31:0] rd;

    always #5 clk = ~clk;

    vt_vector_table #(.NUM_CHAN(NCH)) u_vt_vector_table (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .vec_req(vec_req),
        .vec_none(vec_none), .vec_chan(vec_chan), .vec_addr(vec_addr),
        .inj_en(inj_en), .inj_slot(inj_slot)
    );

    function automatic logic [31:0] pat(int s);
        return 32'h1357_9BDF ^ (32'(s) * 32'h0101_0107);
    endfunction

    function automatic int slot_of(int ch);
        return (ch >= NCH) ? 0 : ch + 1;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bwrite(logic [9:0] a, logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bread(logic [9:0] a, output logic [31:0] d);
        bus_addr = a;
        @(negedge clk);
        d = bus_rdata;
    endtask

    task automatic fetch(bit none, int ch);
        vec_req = 1'b1; vec_none = none; vec_chan = 4'(ch);
        @(negedge clk);
        vec_req = 1'b0; vec_none = 1'b0;
    endtask

    task automatic inject(int s);
        inj_en = 1'b1; inj_slot = 4'(s);
        @(negedge clk);
        inj_en = 1'b0;
    endtask

    task automatic fetch_slot(int s);
        if (s == 0) fetch(1'b1, 0);
        else        fetch(1'b0, s - 1);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL R3 watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 vec_addr", vec_addr, 32'h0);
        bread(10'h200, rd); chk("R1 key", rd, 0);
        bread(10'h204, rd); chk("R1 fallback", rd, 0);
        bread(10'h208, rd); chk("R1 eaddr", rd, 0);
        bread(10'h20C, rd); chk("R1 flag", rd, 0);

        // R2 fallback and slot storage
        bwrite(10'h204, FB);
        bread(10'h204, rd); chk("R2 fallback", rd, FB);
        for (int s = 0; s < NS; s++) begin
            expd[s] = pat(s);
            bwrite(10'(4 * s), expd[s]);
        end
        for (int s = 0; s < NS; s++) begin
            bread(10'(4 * s), rd); chk("R2 slot readback", rd, expd[s]);
        end

        // R3/R4 exhaustive channel sweep
        for (int ch = 0; ch < NS; ch++) begin
            fetch(1'b0, ch);
            if (ch >= NCH) chk("R4 out of range", vec_addr, expd[0]);
            else           chk("R3 channel", vec_addr, expd[slot_of(ch)]);
        end
        fetch(1'b1, 3);
        chk("R4 none", vec_addr, expd[0]);
        vec_chan = 4'd7;
        repeat (3) @(negedge clk);
        chk("R3 hold", vec_addr, expd[0]);

        // R6 checking off with two non-key values
        inject(2);
        fetch(1'b0, 1);
        chk("R6 key0 data", vec_addr, expd[2]);
        bwrite(10'h200, 32'h5);
        fetch(1'b0, 1);
        chk("R6 key5 data", vec_addr, expd[2]);
        bread(10'h20C, rd); chk("R6 flag", rd, 0);
        // R13 bus read unchecked
        bwrite(10'h200, 32'hA);
        bread(10'h008, rd); chk("R13 bus read", rd, expd[2]);
        bread(10'h20C, rd); chk("R13 flag", rd, 0);
        // R12 second pulse restores
        inject(2);
        fetch(1'b0, 1);
        chk("R12 restore", vec_addr, expd[2]);
        bread(10'h20C, rd); chk("R12 flag", rd, 0);

        // R5/R7/R9/R11/R12 per-slot sweep
        for (int s = 0; s < NS; s++) begin
            int n;
            n = (s + 1) % NS;
            inject(s);
            fetch_slot(s);
            chk("R5 fallback", vec_addr, FB);
            bread(10'h20C, rd); chk("R7 flag", rd, 1);
            bread(10'h208, rd); chk("R7 eaddr", rd, 32'(4 * s));
            chk("R7 slot number", 32'(rd[8:0] >> 2), 32'(s));
            fetch_slot(n);
            chk("R12 neighbour", vec_addr, expd[n]);
            bwrite(10'h20C, 32'h0);
            bread(10'h20C, rd); chk("R9 write0", rd, 1);
            bwrite(10'h20C, 32'h1);
            bread(10'h20C, rd); chk("R9 clear", rd, 0);
            expd[s] = pat(s) ^ 32'hFFFF_0000;
            bwrite(10'(4 * s), expd[s]);
            fetch_slot(s);
            chk("R11 rewrite", vec_addr, expd[s]);
            bread(10'h20C, rd); chk("R11 flag", rd, 0);
        end

        // R8 first error held
        inject(3);
        fetch(1'b0, 2);
        inject(5);
        fetch(1'b0, 4);
        chk("R8 fallback", vec_addr, FB);
        bread(10'h208, rd); chk("R8 eaddr held", rd, 32'd12);

        // R10 clear and hit in the same cycle
        bus_addr = 10'h20C; bus_wdata = 32'h1; bus_wr = 1'b1;
        vec_req = 1'b1; vec_chan = 4'd4;
        @(negedge clk);
        bus_wr = 1'b0; vec_req = 1'b0;
        bread(10'h20C, rd); chk("R10 flag", rd, 1);
        bread(10'h208, rd); chk("R10 eaddr", rd, 32'd20);
        bwrite(10'h20C, 32'h1);
        bread(10'h20C, rd); chk("R9 final clear", rd, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule